// File: doc/BRIEF.md
# Indirect PHY Management Bridge

This block gives a host access to the management registers of an on-chip PHY through two host-side registers. The first is a 16-bit data port. The second is a control register that holds a PHY register index and two start bits, one for writes and one for reads.

Setting a start bit launches one Clause 22 management frame on an internal MDC/MDIO pair. The block clears the start bit when the frame is done. For a read, it also places the returned word in the data port. The host therefore polls the control register and never drives MDIO itself.

To write a PHY register, the host first loads the data port. It then writes the index together with the write bit. To read a PHY register, the host writes the index together with the read bit. It then polls until the read bit drops, and takes the result from the data port. Index values 0 through 6 select the PHY's control, status, two identifier, advertisement, partner-ability and expansion registers.

Top module: `phy_mgmt_bridge`

## Requirements
- R1: After reset the data port and the control register read 0, MDC is low and the MDIO output enable is low.
- R2: While no frame runs, a host write with `host_addr`=0 stores `host_wdata` into the data port. The data port reads back on `host_rdata` when `host_addr`=0.
- R3: The control register (`host_addr`=1) holds the index in bits 4:0, the write-start bit in bit 5 and the read-start bit in bit 6. Bits 15:7 read as 0. Writing it with bit 5 or bit 6 set starts a frame on the next clock.
- R4: While a frame runs, MDC starts low and toggles every `MDC_HALF` clocks. A frame lasts exactly 64 MDC periods. MDC stays low when no frame runs.
- R5: The bits of a write frame on MDIO are as follows, one per MDC period, MSB first within each field. There are 32 ones, then 01, then opcode 01, then `PHY_ADDR`, then the index, then turnaround 10, then the 16 data-port bits. MDIO changes only after a falling MDC edge.
- R6: A read frame sends opcode 10. The output enable goes low from the turnaround (bit 46 of the frame) to the end of the frame. In every other bit of a frame the output enable is high.
- R7: A read samples `mdio_i` on the rising MDC edges of frame bits 48 to 63, MSB first. The 16-bit word enters the data port on the same clock that the read bit clears.
- R8: The start bit clears by itself on the clock that ends the frame. On that clock MDC returns low and stays low.
- R9: A control write with both start bits set runs a write frame. It leaves the read bit at 0.
- R10: Host writes to either register while a frame runs have no effect.
- R11: A control write with neither start bit set only updates the index and starts no frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Host register write strobe |
| host_addr | input | 1 | 0 selects the data port, 1 selects the control register |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Contents of the selected register |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | Management data driven toward the PHY |
| mdio_oe | output | 1 | Output enable for `mdio_o` |
| mdio_i | input | 1 | Management data returned by the PHY |

## Verification
Each internal fault shows up at the ports quickly:
- A wrong bit counter or shift register shows as a wrong MDIO level or output enable within one MDC period of the fault.
- A wrong divider shows on MDC within `MDC_HALF` clocks.
- A start bit that fails to clear keeps MDC toggling past the 64th period. It also makes the host's poll of the control register hang.
- A capture slip shows only when the data port is read after the read bit drops, as a word shifted by one or more places.

The bench runs a behavioural model in step with the design. Every clock it compares MDC, the output enable, MDIO and the selected register, so each of these faults is reported in the cycle it first appears.

// File: rtl/phy_mgmt_bridge.sv
module phy_mgmt_bridge #(
  parameter int         MDC_HALF = 4,
  parameter logic [4:0] PHY_ADDR = 5'd1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_we,
  input  logic        host_addr,
  input  logic [15:0] host_wdata,
  output logic [15:0] host_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  localparam int CW = (MDC_HALF > 1) ? $clog2(MDC_HALF) : 1;

  logic [15:0] data_q, rx_q;
  logic [4:0]  idx_q;
  logic        wr_q, rd_q, mdc_q;
  logic [CW-1:0] cnt_q;
  logic [5:0]  bit_q;
  logic [63:0] sr_q;

  wire busy = wr_q | rd_q;
  wire tick = busy && (cnt_q == CW'(MDC_HALF - 1));
  wire rise = tick && !mdc_q;
  wire fall = tick && mdc_q;
  wire done = fall && (bit_q == 6'd63);
  wire wr_go = host_wdata[5];
  wire rd_go = host_wdata[6] & ~host_wdata[5];
  wire [63:0] frame = {32'hFFFF_FFFF, 2'b01, wr_go ? 2'b01 : 2'b10,
                       PHY_ADDR, host_wdata[4:0], 2'b10, data_q};

  assign host_rdata = host_addr ? {9'd0, rd_q, wr_q, idx_q} : data_q;
  assign mdc        = mdc_q;
  assign mdio_o     = busy & sr_q[63];
  assign mdio_oe    = busy && !(rd_q && bit_q >= 6'd46);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0; rx_q <= '0; idx_q <= '0;
      wr_q <= 1'b0; rd_q <= 1'b0; mdc_q <= 1'b0;
      cnt_q <= '0; bit_q <= '0; sr_q <= '0;
    end else if (!busy) begin
      if (host_we && !host_addr) data_q <= host_wdata;
      if (host_we && host_addr) begin
        idx_q <= host_wdata[4:0];
        wr_q  <= wr_go;
        rd_q  <= rd_go;
        sr_q  <= frame;
        cnt_q <= '0;
        bit_q <= '0;
        mdc_q <= 1'b0;
      end
    end else begin
      cnt_q <= tick ? '0 : cnt_q + 1'b1;
      if (tick) mdc_q <= ~mdc_q;
      if (rise && rd_q && bit_q >= 6'd48) rx_q <= {rx_q[14:0], mdio_i};
      if (fall) begin
        sr_q  <= {sr_q[62:0], 1'b0};
        bit_q <= bit_q + 1'b1;
      end
      if (done) begin
        wr_q <= 1'b0;
        rd_q <= 1'b0;
        if (rd_q) data_q <= rx_q;
      end
    end
  end

  p_mdc_idle_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc);
  p_mdio_on_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$past(fall)) |-> $stable(mdio_o));
  p_oe_on_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$past(fall)) |-> $stable(mdio_oe));
  p_read_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && rd_q) |=> (data_q == $past(rx_q)));
  p_end_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!busy && !mdc));
  p_one_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_q && rd_q));
  p_busy_locks_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && host_we) |=> $stable(idx_q));
  p_data_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && host_we && !host_addr) |=> (data_q == $past(host_wdata)));
endmodule

// File: tb/sim_phy_mgmt_bridge.sv
`timescale 1ns/100ps
module sim_phy_mgmt_bridge;
  localparam int H = 3;
  localparam logic [4:0] PA = 5'd9;

  logic clk = 1'b0, rst_n = 1'b0;
  logic host_we = 1'b0, host_addr = 1'b0, mdio_i = 1'b1;
  logic [15:0] host_wdata = '0;
  logic [15:0] host_rdata;
  logic mdc, mdio_o, mdio_oe;
  int checks = 0, errors = 0;
  bit run = 0;

  always #2.5 clk = ~clk;

  phy_mgmt_bridge #(.MDC_HALF(H), .PHY_ADDR(PA)) u0 (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i));

  function automatic logic [15:0] phy_val(input logic [4:0] i);
    return 16'hA5C3 ^ (16'(i) * 16'h1111);
  endfunction

  function automatic logic [63:0] mk_frame(input bit rd, input logic [4:0] i, input logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b01, rd ? 2'b10 : 2'b01, PA, i, 2'b10, d};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model
  logic [15:0] m_data;
  logic [4:0]  m_idx;
  bit m_wr, m_rd, m_act, m_isrd;
  int t;
  logic [63:0] m_frame;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_data = '0; m_idx = '0; m_wr = 0; m_rd = 0; m_act = 0; t = 0;
    end else if (m_act) begin
      t++;
      if (t == 128 * H) begin
        m_act = 0;
        if (m_isrd) m_data = phy_val(m_idx);
        m_wr = 0; m_rd = 0;
      end
    end else if (host_we) begin
      if (!host_addr) m_data = host_wdata;
      else begin
        m_idx = host_wdata[4:0];
        m_wr  = host_wdata[5];
        m_rd  = host_wdata[6] && !host_wdata[5];
        if (m_wr || m_rd) begin
          m_act = 1; t = 0; m_isrd = m_rd;
          m_frame = mk_frame(m_isrd, m_idx, m_data);
        end
      end
    end
  end

  always @(negedge clk) begin
    if (run) begin
      int b;
      b = t / (2 * H);
      check("R4 mdc", 32'(mdc), m_act ? 32'((t / H) % 2) : 32'd0);
      check("R6 mdio_oe", 32'(mdio_oe), 32'(m_act && !(m_isrd && b >= 46)));
      if (m_act && !(m_isrd && b >= 46)) check("R5 mdio_o", 32'(mdio_o), 32'(m_frame[63 - b]));
      if (host_addr) check("R3 control readback", 32'(host_rdata), 32'({9'd0, m_rd, m_wr, m_idx}));
      else check("R2 data readback", 32'(host_rdata), 32'(m_data));
      if (m_act && m_isrd && b >= 48) mdio_i <= phy_val(m_idx)[15 - (b - 48)];
      else mdio_i <= 1'b1;
    end
  end

  task automatic hw(input logic a, input logic [15:0] d);
    @(posedge clk); #1;
    host_we = 1'b1; host_addr = a; host_wdata = d;
    @(posedge clk); #1;
    host_we = 1'b0;
  endtask

  task automatic hr(input logic a, output logic [15:0] v);
    @(posedge clk); #1;
    host_addr = a;
    @(negedge clk);
    v = host_rdata;
  endtask

  task automatic wait_idle();
    logic [15:0] v;
    do hr(1'b1, v); while (v[6:5] != 2'b00);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check("R1 mdc reset", 32'(mdc), 0);
    check("R1 oe reset", 32'(mdio_oe), 0);
    check("R1 data reset", 32'(host_rdata), 0);
    hr(1'b1, v); check("R1 control reset", 32'(v), 0);
    run = 1;

    hw(1'b0, 16'hBEEF);
    hr(1'b0, v); check("R2 data port", 32'(v), 32'hBEEF);

    hw(1'b1, 16'h0003);
    repeat (10) @(negedge clk);
    hr(1'b1, v); check("R11 index only", 32'(v), 32'h0003);
    check("R11 no mdc", 32'(mdc), 0);

    hw(1'b0, 16'h1234);
    hw(1'b1, 16'h0020);
    hr(1'b1, v); check("R3 write bit set", 32'(v), 32'h0020);
    wait_idle();
    check("R8 write bit cleared", 32'(host_rdata), 32'h0000);
    check("R8 mdc low", 32'(mdc), 0);

    hw(1'b1, 16'h0042);
    wait_idle();
    hr(1'b0, v); check("R7 read idx 2", 32'(v), 32'(phy_val(5'd2)));

    hw(1'b1, 16'h0046);
    wait_idle();
    hr(1'b0, v); check("R7 read idx 6", 32'(v), 32'(phy_val(5'd6)));

    hw(1'b0, 16'h5A5A);
    hw(1'b1, 16'h0064);
    hr(1'b1, v); check("R9 write wins", 32'(v), 32'h0024);
    wait_idle();

    hw(1'b0, 16'h0F0F);
    hw(1'b1, 16'h0025);
    hw(1'b0, 16'h7777);
    hw(1'b1, 16'h0041);
    wait_idle();
    hr(1'b1, v); check("R10 control kept", 32'(v), 32'h0005);
    hr(1'b0, v); check("R10 data kept", 32'(v), 32'h0F0F);

    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule